// File: doc/BRIEF.md
# SPI Serial EEPROM Device Model

This block is a synthesizable SPI target that behaves like a small serial EEPROM. It holds a byte array, a write-enable latch and a status byte. A host talks to it over the four SPI wires in mode 0. Every transaction opens with a one-byte instruction, which may be followed by address and data bytes. The block runs on its own system clock and oversamples the SPI pins, so the SPI clock must be slow relative to that clock.

Reads stream bytes for as long as chip select stays low. The read address wraps from the top of the array back to zero. Writes are gathered into a page-sized buffer and committed to the array only when chip select rises. Once a write is accepted, a busy flag stays up for a programmable number of system clock cycles. During that time only the status-read instruction is served, and at the end the write-enable latch clears.

Two status bits protect a region of the array against writes. A parameter selects the address format: one byte, two bytes, three bytes, or one byte plus a ninth bit carried in bit 3 of the instruction.

Top module: `spi_eeprom_model`

## Requirements
- R1: Instruction 0x06 sets and 0x04 clears the write-enable latch. Either takes effect at chip-select rise, and only when exactly 8 SCK cycles were sent in that selection.
- R2: Instruction 0x05 returns the status byte and repeats it for as long as SCK keeps running. The status byte holds busy in bit 0, write-enable in bit 1, the protect field in bits 3:2 and protect-enable in bit 7. All other bits read 0.
- R3: Instruction 0x03 takes the address bytes MSB first (1, 2 or 3 bytes, set by the mode). It then returns the data MSB first, one byte per following 8 SCK cycles, at consecutive addresses.
- R4: A read that passes the last array address continues at address 0.
- R5: In the nine-bit address mode, one address byte is sent and bit 3 of the instruction is address bit 8, for both read (0x03/0x0B) and write (0x02/0x0A).
- R6: Instruction 0x02 buffers its data bytes and writes them to the array only when chip select rises. A trailing partial byte is discarded.
- R7: Write data that runs past the end of the current page wraps to the first byte of that same page.
- R8: A write or status-write is ignored when the write-enable latch is clear at chip-select rise: the array and status are unchanged and busy stays 0.
- R9: An accepted write or status-write sets busy for BUSY_CYCLES clock cycles. Busy then returns to 0 and the write-enable latch clears.
- R10: While busy, every instruction except 0x05 is ignored: reads return zero bytes, writes and latch changes do nothing.
- R11: Instruction 0x01 writes bits 7, 3 and 2 of its first data byte into the status byte. It starts a busy period like a data write does.
- R12: With the protect field at 01 the upper quarter of the array is protected, at 10 the upper half, and at 11 all of it. Bytes of an accepted write that fall in a protected region are left unchanged.
- R13: MISO changes only after a falling SCK edge and is 0 while chip select is high.
- R14: After reset the status byte is 0x00 and every array byte is 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SPI pins are oversampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI clock from the host, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host, sampled on SCK rise |
| spi_miso | output | 1 | Serial data to host, updated after SCK fall |

## Verification
The assertions take for granted that each SCK level and each chip-select level lasts several system clocks longer than the synchronizer depth. They also assume MOSI is stable around the SCK rise, and that chip select never changes in the same synchronized cycle as an SCK edge. The stimulus keeps to this: every level lasts eight system clocks, MOSI changes only while SCK is low, and chip select moves only after SCK has been low for a full half period. With those rules, the checks on MISO holding and on busy and latch sequencing only ever see clean, ordered edges.

// File: rtl/spi_eeprom_pkg.sv
// Shared opcodes, status bit positions and enums for the SPI EEPROM model.
package spi_eeprom_pkg;

    typedef enum logic [1:0] {
        AM_8  = 2'd0,
        AM_9  = 2'd1,
        AM_16 = 2'd2,
        AM_24 = 2'd3
    } addr_mode_e;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    typedef enum logic [2:0] {
        CMD_NONE, CMD_WREN, CMD_WRDI, CMD_RDSR, CMD_WRSR, CMD_READ, CMD_WRITE
    } cmd_e;

    typedef enum logic [1:0] {PH_OP, PH_ADDR, PH_DATA, PH_SKIP} phase_e;

    // Number of address bytes sent after the instruction.
    function automatic logic [1:0] addr_bytes(addr_mode_e m);
        case (m)
            AM_16:   return 2'd2;
            AM_24:   return 2'd3;
            default: return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/spi_eeprom_sync.sv
// Pin synchronizer: brings SCK, CS_n and MOSI into the clk domain through
// SYNC_STAGES flops and derives single-cycle edge strobes.
// Assumes each SPI level lasts longer than SYNC_STAGES+1 clk cycles.
module spi_eeprom_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic cs_act_o,
    output logic cs_fall_o,
    output logic cs_rise_o,
    output logic mosi_o
);
    localparam int S = SYNC_STAGES;

    logic [S:0]   sck_p;
    logic [S:0]   cs_p;
    logic [S-1:0] mosi_p;

    // Shift the raw pins through the synchronizer chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_p  <= '0;
            cs_p   <= '1;
            mosi_p <= '0;
        end else begin
            sck_p  <= {sck_p[S-1:0], sck_i};
            cs_p   <= {cs_p[S-1:0], cs_n_i};
            mosi_p <= {mosi_p[S-2:0], mosi_i};
        end
    end

    // Edge strobes from the last two synchronized stages.
    always_comb begin
        sck_rise_o = sck_p[S-1] & ~sck_p[S];
        sck_fall_o = ~sck_p[S-1] & sck_p[S];
        cs_act_o   = ~cs_p[S-1];
        cs_fall_o  = ~cs_p[S-1] & cs_p[S];
        cs_rise_o  = cs_p[S-1] & ~cs_p[S];
        mosi_o     = mosi_p[S-1];
    end

endmodule

// File: rtl/spi_eeprom_status.sv
// Status byte keeper: write-enable latch, protect field, protect-enable bit
// and the busy down-counter that models the internal write time.
// Assumes the command engine raises start only when the latch is set.
module spi_eeprom_status #(
    parameter int BUSY_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wel_set_i,
    input  logic       wel_clr_i,
    input  logic       commit_i,
    input  logic       sr_wr_i,
    input  logic [2:0] sr_data_i,
    output logic [7:0] status_o,
    output logic       wel_o,
    output logic       busy_o,
    output logic [1:0] bp_o
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] BUSY_LOAD = CW'(BUSY_CYCLES);

    logic [CW-1:0] busy_cnt;
    logic          wel_q;
    logic [1:0]    bp_q;
    logic          wpen_q;
    logic          start;

    assign start = commit_i | sr_wr_i;

    // Busy countdown, latch set/clear and status field updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            wel_q    <= 1'b0;
            bp_q     <= 2'b00;
            wpen_q   <= 1'b0;
        end else begin
            if (start) begin
                busy_cnt <= BUSY_LOAD;
                if (sr_wr_i) begin
                    wpen_q <= sr_data_i[2];
                    bp_q   <= sr_data_i[1:0];
                end
            end else if (busy_cnt != '0) begin
                busy_cnt <= busy_cnt - 1'b1;
                if (busy_cnt == CW'(1)) wel_q <= 1'b0;
            end else if (wel_set_i) begin
                wel_q <= 1'b1;
            end else if (wel_clr_i) begin
                wel_q <= 1'b0;
            end
        end
    end

    // Assemble the visible status byte.
    always_comb begin
        busy_o   = (busy_cnt != '0);
        wel_o    = wel_q;
        bp_o     = bp_q;
        status_o = {wpen_q, 3'b000, bp_q, wel_q, busy_o};
    end

    p_wel_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !wel_o);

    p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy_cnt == BUSY_LOAD));

    p_wel_needed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(wel_o));

    p_bp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(bp_o));

endmodule

// File: rtl/spi_eeprom_array.sv
// Byte array: asynchronous read port and a one-cycle page commit that skips
// bytes inside the region selected by the protect field.
// Assumes MEM_BYTES and PAGE_BYTES are powers of two with MEM_BYTES > PAGE_BYTES.
module spi_eeprom_array #(
    parameter int MEM_BYTES  = 512,
    parameter int PAGE_BYTES = 16,
    localparam int AW = $clog2(MEM_BYTES),
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [AW-1:0]               rd_addr_i,
    output logic [7:0]                  rd_data_o,
    input  logic                        commit_i,
    input  logic [AW-PW-1:0]            commit_page_i,
    input  logic [PAGE_BYTES-1:0][7:0]  commit_data_i,
    input  logic [PAGE_BYTES-1:0]       commit_mask_i,
    input  logic [1:0]                  bp_i
);
    localparam logic [AW-1:0] HALF_BASE = AW'(MEM_BYTES / 2);
    localparam logic [AW-1:0] QTR_BASE  = AW'(MEM_BYTES - MEM_BYTES / 4);

    logic [7:0] mem_q [MEM_BYTES];

    // True when address a lies in the region guarded by protect field bp.
    function automatic logic is_prot(logic [AW-1:0] a, logic [1:0] bp);
        case (bp)
            2'b01:   return a >= QTR_BASE;
            2'b10:   return a >= HALF_BASE;
            2'b11:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Erase on reset; commit the buffered page on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'hFF;
        end else if (commit_i) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (commit_mask_i[i] && !is_prot({commit_page_i, PW'(i)}, bp_i))
                    mem_q[{commit_page_i, PW'(i)}] <= commit_data_i[i];
            end
        end
    end

    // Read port for the serial output path.
    assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/spi_eeprom_engine.sv
// Command engine: assembles MOSI bits into bytes, decodes the instruction,
// collects the address, streams read data or status on MISO, buffers write
// data within one page and raises the commit/latch strobes at CS rise.
// Assumes strobes come from spi_eeprom_sync and that CS and SCK edges never
// land in the same clk cycle.
module spi_eeprom_engine
    import spi_eeprom_pkg::*;
#(
    parameter int         MEM_BYTES  = 512,
    parameter int         PAGE_BYTES = 16,
    parameter addr_mode_e ADDR_MODE  = AM_9,
    localparam int AW = $clog2(MEM_BYTES),
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sck_rise_i,
    input  logic                        sck_fall_i,
    input  logic                        cs_act_i,
    input  logic                        cs_fall_i,
    input  logic                        cs_rise_i,
    input  logic                        mosi_i,
    input  logic [7:0]                  status_i,
    input  logic                        wel_i,
    input  logic                        busy_i,
    output logic [AW-1:0]               rd_addr_o,
    input  logic [7:0]                  rd_data_i,
    output logic                        commit_o,
    output logic [AW-PW-1:0]            commit_page_o,
    output logic [PAGE_BYTES-1:0][7:0]  commit_data_o,
    output logic [PAGE_BYTES-1:0]       commit_mask_o,
    output logic                        wel_set_o,
    output logic                        wel_clr_o,
    output logic                        sr_wr_o,
    output logic [2:0]                  sr_data_o,
    output logic                        miso_o
);
    localparam logic [1:0] NAB = addr_bytes(ADDR_MODE);

    logic [6:0]                 shift_q;
    logic [2:0]                 bit_q;
    phase_e                     phase_q;
    cmd_e                       cmd_q;
    logic [15:0]                addr_q;
    logic [1:0]                 abytes_q;
    logic                       a8_q;
    logic                       trail_q;
    logic [AW-1:0]              rd_ptr_q;
    logic [PW-1:0]              wr_off_q;
    logic [AW-PW-1:0]           page_q;
    logic [PAGE_BYTES-1:0][7:0] buf_q;
    logic [PAGE_BYTES-1:0]      mask_q;
    logic                       seen_q;
    logic [2:0]                 sr_byte_q;
    logic [7:0]                 tx_q;
    logic                       miso_q;

    logic [7:0]    byte_in;
    logic          rise;
    logic          byte_done;
    logic [7:0]    op_key;
    cmd_e          dec;
    logic [AW-1:0] full_addr;

    // Decode the current byte and form the full address candidate.
    always_comb begin
        byte_in   = {shift_q, mosi_i};
        rise      = sck_rise_i && cs_act_i;
        byte_done = rise && (bit_q == 3'd7);
        op_key    = (ADDR_MODE == AM_9) ? (byte_in & 8'hF7) : byte_in;
        case (byte_in)
            OP_WREN: dec = CMD_WREN;
            OP_WRDI: dec = CMD_WRDI;
            OP_RDSR: dec = CMD_RDSR;
            OP_WRSR: dec = CMD_WRSR;
            default: begin
                if (op_key == OP_READ)       dec = CMD_READ;
                else if (op_key == OP_WRITE) dec = CMD_WRITE;
                else                         dec = CMD_NONE;
            end
        endcase
        if (busy_i && dec != CMD_RDSR) dec = CMD_NONE;
        if (ADDR_MODE == AM_9) full_addr = AW'({a8_q, byte_in});
        else                   full_addr = AW'({addr_q, byte_in});
        rd_addr_o = (phase_q == PH_ADDR) ? full_addr : rd_ptr_q;
    end

    // Serial byte assembly, phase sequencing, read prefetch and write buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q   <= '0;
            bit_q     <= '0;
            phase_q   <= PH_OP;
            cmd_q     <= CMD_NONE;
            addr_q    <= '0;
            abytes_q  <= '0;
            a8_q      <= 1'b0;
            trail_q   <= 1'b0;
            rd_ptr_q  <= '0;
            wr_off_q  <= '0;
            page_q    <= '0;
            buf_q     <= '0;
            mask_q    <= '0;
            seen_q    <= 1'b0;
            sr_byte_q <= '0;
            tx_q      <= '0;
        end else if (cs_fall_i || cs_rise_i) begin
            bit_q   <= '0;
            phase_q <= PH_OP;
            cmd_q   <= CMD_NONE;
            trail_q <= 1'b0;
            mask_q  <= '0;
            seen_q  <= 1'b0;
            tx_q    <= '0;
        end else if (rise) begin
            shift_q <= byte_in[6:0];
            bit_q   <= bit_q + 3'd1;
            if (phase_q != PH_OP) trail_q <= 1'b1;
            if (byte_done) begin
                case (phase_q)
                    PH_OP: begin
                        cmd_q    <= dec;
                        a8_q     <= byte_in[3];
                        abytes_q <= NAB;
                        addr_q   <= '0;
                        case (dec)
                            CMD_READ, CMD_WRITE: phase_q <= PH_ADDR;
                            CMD_RDSR: begin
                                phase_q <= PH_DATA;
                                tx_q    <= status_i;
                            end
                            CMD_NONE: phase_q <= PH_SKIP;
                            default:  phase_q <= PH_DATA;
                        endcase
                    end
                    PH_ADDR: begin
                        addr_q   <= {addr_q[7:0], byte_in};
                        abytes_q <= abytes_q - 2'd1;
                        if (abytes_q == 2'd1) begin
                            phase_q  <= PH_DATA;
                            rd_ptr_q <= full_addr + 1'b1;
                            wr_off_q <= full_addr[PW-1:0];
                            page_q   <= full_addr[AW-1:PW];
                            if (cmd_q == CMD_READ) tx_q <= rd_data_i;
                        end
                    end
                    PH_DATA: begin
                        case (cmd_q)
                            CMD_READ: begin
                                tx_q     <= rd_data_i;
                                rd_ptr_q <= rd_ptr_q + 1'b1;
                            end
                            CMD_RDSR: tx_q <= status_i;
                            CMD_WRITE: begin
                                buf_q[wr_off_q]  <= byte_in;
                                mask_q[wr_off_q] <= 1'b1;
                                wr_off_q         <= wr_off_q + 1'b1;
                                seen_q           <= 1'b1;
                            end
                            CMD_WRSR: begin
                                if (!seen_q) sr_byte_q <= {byte_in[7], byte_in[3:2]};
                                seen_q <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
        end else if (sck_fall_i && cs_act_i) begin
            tx_q <= {tx_q[6:0], 1'b0};
        end
    end

    // MISO register: next MSB after each SCK fall, held low when deselected.
    always_ff @(posedge clk) begin
        if (!rst_n)                     miso_q <= 1'b0;
        else if (!cs_act_i)             miso_q <= 1'b0;
        else if (sck_fall_i)            miso_q <= tx_q[7];
    end

    // End-of-selection strobes toward the status keeper and array.
    always_comb begin
        wel_set_o     = cs_rise_i && cmd_q == CMD_WREN && !trail_q && bit_q == 3'd0;
        wel_clr_o     = cs_rise_i && cmd_q == CMD_WRDI && !trail_q && bit_q == 3'd0;
        commit_o      = cs_rise_i && cmd_q == CMD_WRITE && phase_q == PH_DATA
                        && seen_q && wel_i;
        sr_wr_o       = cs_rise_i && cmd_q == CMD_WRSR && seen_q && wel_i;
        sr_data_o     = sr_byte_q;
        commit_page_o = page_q;
        commit_data_o = buf_q;
        commit_mask_o = mask_q;
        miso_o        = miso_q;
    end

    p_miso_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_rise_i && cs_act_i) |=> $stable(miso_q));

endmodule

// File: rtl/spi_eeprom_model.sv
// Top of the SPI serial EEPROM model: synchronizer, command engine, status
// keeper and byte array. Assumes SCK half periods of at least SYNC_STAGES+2 clk.
module spi_eeprom_model
    import spi_eeprom_pkg::*;
#(
    parameter int         MEM_BYTES   = 512,
    parameter int         PAGE_BYTES  = 16,
    parameter addr_mode_e ADDR_MODE   = AM_9,
    parameter int         BUSY_CYCLES = 2000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);

    logic sck_rise, sck_fall, cs_act, cs_fall, cs_rise, mosi_s;
    logic [7:0] status;
    logic wel, busy;
    logic [1:0] bp;
    logic [AW-1:0] rd_addr;
    logic [7:0] rd_data;
    logic commit;
    logic [AW-PW-1:0] commit_page;
    logic [PAGE_BYTES-1:0][7:0] commit_data;
    logic [PAGE_BYTES-1:0] commit_mask;
    logic wel_set, wel_clr, sr_wr;
    logic [2:0] sr_data;

    spi_eeprom_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .cs_n_i(spi_cs_n),
        .mosi_i(spi_mosi), .sck_rise_o(sck_rise), .sck_fall_o(sck_fall),
        .cs_act_o(cs_act), .cs_fall_o(cs_fall), .cs_rise_o(cs_rise),
        .mosi_o(mosi_s)
    );

    spi_eeprom_engine #(
        .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .ADDR_MODE(ADDR_MODE)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .sck_rise_i(sck_rise), .sck_fall_i(sck_fall),
        .cs_act_i(cs_act), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
        .mosi_i(mosi_s), .status_i(status), .wel_i(wel), .busy_i(busy),
        .rd_addr_o(rd_addr), .rd_data_i(rd_data), .commit_o(commit),
        .commit_page_o(commit_page), .commit_data_o(commit_data),
        .commit_mask_o(commit_mask), .wel_set_o(wel_set), .wel_clr_o(wel_clr),
        .sr_wr_o(sr_wr), .sr_data_o(sr_data), .miso_o(spi_miso)
    );

    spi_eeprom_status #(.BUSY_CYCLES(BUSY_CYCLES)) u_status (
        .clk(clk), .rst_n(rst_n), .wel_set_i(wel_set), .wel_clr_i(wel_clr),
        .commit_i(commit), .sr_wr_i(sr_wr), .sr_data_i(sr_data),
        .status_o(status), .wel_o(wel), .busy_o(busy), .bp_o(bp)
    );

    spi_eeprom_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .commit_i(commit), .commit_page_i(commit_page),
        .commit_data_i(commit_data), .commit_mask_i(commit_mask), .bp_i(bp)
    );

    p_no_commit_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (commit || sr_wr) |-> !busy);

    p_miso_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act && !$past(cs_act)) |-> !spi_miso);

endmodule

// File: tb/spi_eeprom_model_tb_top.sv
// Directed bench for the SPI EEPROM model: one task per scenario.
module spi_eeprom_model_tb_top;
    localparam int TB_BUSY = 2000;
    localparam int HALF    = 8;
    localparam int MEMB    = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_mem [MEMB];
    logic [7:0] rbuf [0:31];
    logic [7:0] wbuf [0:31];

    always #4 clk = ~clk;

    spi_eeprom_model #(.MEM_BYTES(MEMB), .PAGE_BYTES(16), .BUSY_CYCLES(TB_BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nb; i--) begin
            mosi = tx[i];
            clks(HALF);
            rx[i] = miso;
            sck = 1'b1;
            clks(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_bits(tx, 8, rx);
    endtask

    task automatic sel();
        cs_n = 1'b0;
        clks(HALF);
    endtask

    task automatic desel();
        clks(HALF);
        cs_n = 1'b1;
        clks(2 * HALF);
    endtask

    task automatic op1(input logic [7:0] op);
        logic [7:0] d;
        sel(); xfer(op, d); desel();
    endtask

    task automatic rdsr(output logic [7:0] sr);
        logic [7:0] d;
        sel(); xfer(8'h05, d); xfer(8'h00, sr); desel();
    endtask

    task automatic do_read(input logic [8:0] a, input int n);
        logic [7:0] d;
        sel();
        xfer(8'h03 | {4'b0, a[8], 3'b0}, d);
        xfer(a[7:0], d);
        for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
        desel();
    endtask

    task automatic do_write(input logic [8:0] a, input int n, input int tail_bits);
        logic [7:0] d;
        sel();
        xfer(8'h02 | {4'b0, a[8], 3'b0}, d);
        xfer(a[7:0], d);
        for (int i = 0; i < n; i++) xfer(wbuf[i], d);
        if (tail_bits > 0) xfer_bits(8'hFF, tail_bits, d);
        desel();
    endtask

    function automatic logic prot(input logic [8:0] a, input logic [1:0] bp);
        case (bp)
            2'b01: return a >= 9'd384;
            2'b10: return a >= 9'd256;
            2'b11: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic void model_write(input logic [8:0] a, input int n, input logic [1:0] bp);
        for (int i = 0; i < n; i++) begin
            logic [8:0] t;
            t = {a[8:4], 4'(a[3:0] + i)};
            if (!prot(t, bp)) exp_mem[t] = wbuf[i];
        end
    endfunction

    task automatic wait_ready();
        clks(TB_BUSY + 100);
    endtask

    task automatic t_reset();
        logic [7:0] sr;
        check("R13 miso idle", {7'b0, miso}, 8'h00);
        rdsr(sr);
        check("R14 status after reset", sr, 8'h00);
        do_read(9'h000, 2);
        check("R14 erased byte 0", rbuf[0], 8'hFF);
        check("R14 erased byte 1", rbuf[1], 8'hFF);
    endtask

    task automatic t_wel();
        logic [7:0] sr, d;
        op1(8'h06); rdsr(sr);
        check("R1 set latch", sr, 8'h02);
        op1(8'h04); rdsr(sr);
        check("R1 clear latch", sr, 8'h00);
        sel(); xfer(8'h06, d); xfer(8'h00, d); desel();
        rdsr(sr);
        check("R1 extra clocks ignored", sr, 8'h00);
        sel(); xfer(8'h05, d); xfer(8'h00, d); xfer(8'h00, sr); desel();
        check("R2 repeated status", sr, 8'h00);
    endtask

    task automatic t_no_wel();
        logic [7:0] sr;
        wbuf[0] = 8'h5C;
        do_write(9'h010, 1, 0);
        rdsr(sr);
        check("R8 no busy without latch", sr, 8'h00);
        do_read(9'h010, 1);
        check("R8 array unchanged", rbuf[0], 8'hFF);
    endtask

    task automatic t_write_partial();
        logic [7:0] sr;
        wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
        op1(8'h06);
        do_write(9'h020, 3, 4);
        model_write(9'h020, 3, 2'b00);
        rdsr(sr);
        check("R9 busy and latch during write", sr, 8'h03);
        wait_ready();
        rdsr(sr);
        check("R9 busy done latch cleared", sr, 8'h00);
        do_read(9'h020, 4);
        for (int i = 0; i < 4; i++) check("R6 R3 sequential readback", rbuf[i], exp_mem[9'h020 + i]);
    endtask

    task automatic t_page_wrap();
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        op1(8'h06);
        do_write(9'h02E, 4, 0);
        model_write(9'h02E, 4, 2'b00);
        wait_ready();
        do_read(9'h020, 16);
        for (int i = 0; i < 16; i++) check("R7 page wrap", rbuf[i], exp_mem[9'h020 + i]);
        check("R7 wrapped byte at page start", rbuf[0], 8'h33);
    endtask

    task automatic t_a9();
        wbuf[0] = 8'hB5;
        op1(8'h06);
        do_write(9'h105, 1, 0);
        model_write(9'h105, 1, 2'b00);
        wait_ready();
        do_read(9'h105, 1);
        check("R5 high half read", rbuf[0], 8'hB5);
        do_read(9'h005, 1);
        check("R5 low half untouched", rbuf[0], 8'hFF);
    endtask

    task automatic t_read_wrap();
        wbuf[0] = 8'h5A;
        op1(8'h06);
        do_write(9'h1FF, 1, 0);
        model_write(9'h1FF, 1, 2'b00);
        wbuf[0] = 8'hC3;
        op1(8'h06);
        wait_ready();
        op1(8'h06);
        do_write(9'h000, 1, 0);
        model_write(9'h000, 1, 2'b00);
        wait_ready();
        do_read(9'h1FF, 2);
        check("R4 last byte", rbuf[0], 8'h5A);
        check("R4 wrap to zero", rbuf[1], 8'hC3);
    endtask

    task automatic t_busy_block();
        logic [7:0] sr;
        wbuf[0] = 8'h6E;
        op1(8'h06);
        do_write(9'h040, 1, 0);
        model_write(9'h040, 1, 2'b00);
        do_read(9'h040, 1);
        check("R10 read ignored while busy", rbuf[0], 8'h00);
        wbuf[0] = 8'h22;
        do_write(9'h041, 1, 0);
        op1(8'h04);
        rdsr(sr);
        check("R10 latch change ignored", sr, 8'h03);
        wait_ready();
        do_read(9'h040, 2);
        check("R10 first write landed", rbuf[0], 8'h6E);
        check("R10 busy write dropped", rbuf[1], 8'hFF);
    endtask

    task automatic t_wrsr_protect();
        logic [7:0] sr, d;
        op1(8'h06);
        sel(); xfer(8'h01, d); xfer(8'hFF, d); desel();
        rdsr(sr);
        check("R11 status write busy", sr[1:0], 2'b11);
        wait_ready();
        rdsr(sr);
        check("R11 writable bits only", sr, 8'h8C);
        wbuf[0] = 8'h77;
        op1(8'h06);
        do_write(9'h000, 1, 0);
        wait_ready();
        do_read(9'h000, 1);
        check("R12 whole array protected", rbuf[0], exp_mem[0]);
        op1(8'h06);
        sel(); xfer(8'h01, d); xfer(8'h04, d); desel();
        wait_ready();
        rdsr(sr);
        check("R11 quarter field", sr, 8'h04);
        wbuf[0] = 8'h33;
        op1(8'h06); do_write(9'h1F0, 1, 0); wait_ready();
        wbuf[0] = 8'h44;
        op1(8'h06); do_write(9'h0F0, 1, 0); wait_ready();
        model_write(9'h0F0, 1, 2'b01);
        do_read(9'h1F0, 1);
        check("R12 upper quarter kept", rbuf[0], 8'hFF);
        do_read(9'h0F0, 1);
        check("R12 lower area written", rbuf[0], 8'h44);
        check("R13 miso low deselected", {7'b0, miso}, 8'h00);
    endtask

    initial begin : watchdog
        clks(180000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < MEMB; i++) exp_mem[i] = 8'hFF;
        clks(5);
        rst_n = 1'b1;
        clks(5);
        t_reset();
        t_wel();
        t_no_wel();
        t_write_partial();
        t_page_wrap();
        t_a9();
        t_read_wrap();
        t_busy_block();
        t_wrsr_protect();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule